// File: doc/BRIEF.md
# Reset Source Controller

This block merges four reset requests into a single system reset and remembers which one caused the most recent reset. The four requests are an active-low reset pin, a one-cycle clock-loss timeout pulse, a comparator output that requests reset when low, and a supply-low indication. The block's own registers are cleared only by a separate power-on reset (`por_n`), so the recorded cause and the source enables survive the system reset that the block produces.

The pin can always reset the device. The three other sources are armed from software over a small register bus. A source should be armed only after its analog circuit has settled. Writing a bit of the source register arms or disarms that source. Reading the same bit returns whether that source caused the last reset. The supply source needs a second enable as well, held in a monitor register, which also reports the live supply status. Any request holds the system reset for a programmable number of cycles after the request goes away. The reset is released on a clock edge. For a reset raised by the supply or comparator source, the block also asks the pad to pull the reset pin low.

Top module: `rstctl_top`

## Requirements
- R1: With `ext_rst_n` held low, `sys_rst` is 1 from the third rising edge onward, after a two-flop synchronizer. A pin-caused reset sets bit 0 of the source register (address 0).
- R2: With bit 2 of the source register written as 1, a `clk_lost` pulse makes `sys_rst` 1 after the next edge, and bit 2 then reads 1. With bit 2 written as 0, the pulse has no effect.
- R3: With bit 5 of the source register written as 1, a low `cmp_out` raises `sys_rst` on the third edge after the low level is applied, and bit 5 then reads 1. With bit 5 written as 0, a low `cmp_out` has no effect.
- R4: A high `sup_low` raises `sys_rst` only when two bits are both 1: bit 7 of the monitor register (address 1) and bit 1 of the source register. Bit 1 of the source register then reads 1.
- R5: When a reset starts, exactly one cause bit is set and all the others are cleared. When several sources request together, the winner is chosen in this order: pin, then supply, then clock loss, then comparator. Writes do not change the cause bits.
- R6: `sys_rst` stays 1 while any request is present and for HOLD (default 16) more edges after the last edge at which a request was seen. It then falls on a clock edge. A single-cycle `clk_lost` pulse therefore gives a reset HOLD+1 cycles wide.
- R7: `pin_drv` is 1 during a reset caused by the supply or comparator source. It is never 1 for a reset caused by clock loss or by the pin.
- R8: The monitor register reads as follows. Bit 7 is the monitor enable (power-on value 1). Bit 6 is the live supply status (1 when `sup_low` is 0, after synchronization), and writes to it are ignored. Bits 5..0 read 0 and ignore writes.
- R9: While `por_n` is low, `sys_rst` is 1, all cause bits and source enables are 0, and the monitor enable is 1. After `por_n` rises, `sys_rst` stays 1 for HOLD+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the block's own state, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clk_lost | input | 1 | Clock-loss timeout pulse, synchronous |
| cmp_out | input | 1 | Comparator output; low requests reset, asynchronous |
| sup_low | input | 1 | Supply at or below threshold, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = source register, 1 = monitor register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sys_rst | output | 1 | Synchronous system reset, active high |
| pin_drv | output | 1 | Request to pull the reset pin low |

## Verification
The bench walks through each source both disarmed and armed. A design that ignored an enable would reset on a disarmed input, and a design that required extra enables would fail to reset on an armed one. The bench fires sources in pairs and checks the cause bits after each reset, which catches a wrong priority order or a stale flag left from an earlier reset. Reset widths are counted cycle by cycle for a one-cycle pulse, for a held level and after power-on, so an off-by-one in the hold counter or a missing synchronizer stage changes the count. The pull-down request is checked for every cause, which exposes a design that drives the pin after a clock loss.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  // Source index order is also the priority order (index 0 wins).
  typedef enum logic [1:0] {
    SRC_PIN = 2'd0,
    SRC_SUP = 2'd1,
    SRC_MCD = 2'd2,
    SRC_CMP = 2'd3
  } src_e;

  localparam int NSRC = 4;
  localparam int DW   = 8;

  // Bit positions in the source register (read: cause, write: enable).
  localparam int SRCB_PIN = 0;
  localparam int SRCB_SUP = 1;
  localparam int SRCB_MCD = 2;
  localparam int SRCB_CMP = 5;

  // Bit positions in the monitor register.
  localparam int MONB_EN   = 7;
  localparam int MONB_STAT = 6;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rstctl_arb.sv
module rstctl_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] above;
  assign above[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      assign above[i+1] = above[i] | req[i];
      assign grant[i]   = req[i] & ~above[i];
    end
  endgenerate
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic req,
  output logic rst_o,
  output logic start_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= CW'(HOLD);
      rst_q <= 1'b1;
    end else if (req) begin
      cnt   <= CW'(HOLD);
      rst_q <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - CW'(1);
      rst_q <= 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign rst_o   = rst_q;
  assign start_o = req & ~rst_q;
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic            wr,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  input  logic            capture,
  input  logic [NSRC-1:0] grant,
  input  logic            sup_ok,
  output logic [DW-1:0]   rdata,
  output logic            mcd_en,
  output logic            cmp_en,
  output logic            sup_sel,
  output logic            mon_en,
  output logic [NSRC-1:0] cause
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mcd_en  <= 1'b0;
      cmp_en  <= 1'b0;
      sup_sel <= 1'b0;
      mon_en  <= 1'b1;
    end else if (wr) begin
      if (!addr) begin
        mcd_en  <= wdata[SRCB_MCD];
        cmp_en  <= wdata[SRCB_CMP];
        sup_sel <= wdata[SRCB_SUP];
      end else begin
        mon_en  <= wdata[MONB_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cause <= '0;
    else if (capture) cause <= grant;
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[SRCB_PIN] = cause[int'(SRC_PIN)];
      rdata[SRCB_SUP] = cause[int'(SRC_SUP)];
      rdata[SRCB_MCD] = cause[int'(SRC_MCD)];
      rdata[SRCB_CMP] = cause[int'(SRC_CMP)];
    end else begin
      rdata[MONB_EN]   = mon_en;
      rdata[MONB_STAT] = sup_ok;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[0], wdata[4:3], wdata[6]};
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int HOLD = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ext_rst_n,
  input  logic          clk_lost,
  input  logic          cmp_out,
  input  logic          sup_low,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sys_rst,
  output logic          pin_drv
);
  // Synchronized inputs, packed as {sup_low, cmp_out, ext_rst_n}.
  logic [2:0] async_in, sync_out;
  logic       pin_s, cmp_s, suplow_s;

  assign async_in = {sup_low, cmp_out, ext_rst_n};

  rstctl_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) sync_i (
    .clk  (clk),
    .por_n(por_n),
    .d    (async_in),
    .q    (sync_out)
  );

  assign pin_s    = sync_out[0];
  assign cmp_s    = sync_out[1];
  assign suplow_s = sync_out[2];

  logic            mcd_en, cmp_en, sup_sel, mon_en;
  logic [NSRC-1:0] req_vec, grant_vec, cause_q;
  logic            any_req, start;

  always_comb begin
    req_vec                 = '0;
    req_vec[int'(SRC_PIN)]  = ~pin_s;
    req_vec[int'(SRC_SUP)]  = mon_en & sup_sel & suplow_s;
    req_vec[int'(SRC_MCD)]  = mcd_en & clk_lost;
    req_vec[int'(SRC_CMP)]  = cmp_en & ~cmp_s;
  end

  assign any_req = |req_vec;

  rstctl_arb #(.N(NSRC)) arb_i (
    .req  (req_vec),
    .grant(grant_vec)
  );

  rstctl_stretch #(.HOLD(HOLD)) stretch_i (
    .clk    (clk),
    .por_n  (por_n),
    .req    (any_req),
    .rst_o  (sys_rst),
    .start_o(start)
  );

  rstctl_regs regs_i (
    .clk    (clk),
    .por_n  (por_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .capture(start),
    .grant  (grant_vec),
    .sup_ok (~suplow_s),
    .rdata  (reg_rdata),
    .mcd_en (mcd_en),
    .cmp_en (cmp_en),
    .sup_sel(sup_sel),
    .mon_en (mon_en),
    .cause  (cause_q)
  );

  assign pin_drv = sys_rst & (cause_q[int'(SRC_SUP)] | cause_q[int'(SRC_CMP)]);
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
  import rstctl_pkg::*;
#(
  parameter int HOLD = 16
) (
  input logic            clk,
  input logic            por_n,
  input logic            sys_rst,
  input logic            pin_drv,
  input logic [NSRC-1:0] req,
  input logic [NSRC-1:0] cause,
  input logic            mon_en,
  input logic            sup_sel,
  input logic            cmp_en,
  input logic            mcd_en,
  input logic            clk_lost
);
  localparam int GW = $clog2(HOLD + 2) + 1;

  // Cycles since a request was last seen; power-on counts as a request.
  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              gap <= '0;
    else if (|req)           gap <= '0;
    else if (gap <= GW'(HOLD)) gap <= gap + GW'(1);
  end

  logic starting;
  assign starting = (|req) & ~sys_rst;

  p_pin_resets_r1: assert property (@(posedge clk) disable iff (!por_n)
    req[int'(SRC_PIN)] |=> sys_rst);

  p_mcd_needs_en_r2: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(sys_rst) && cause[int'(SRC_MCD)]) |-> $past(clk_lost && mcd_en));

  p_cmp_needs_en_r3: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(sys_rst) && cause[int'(SRC_CMP)]) |-> $past(cmp_en));

  p_sup_needs_both_r4: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(sys_rst) && cause[int'(SRC_SUP)]) |-> $past(mon_en && sup_sel));

  p_one_cause_r5: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(cause));

  p_pin_wins_r5: assert property (@(posedge clk) disable iff (!por_n)
    (starting && req[int'(SRC_PIN)]) |=> cause[int'(SRC_PIN)]);

  p_sup_second_r5: assert property (@(posedge clk) disable iff (!por_n)
    (starting && req[int'(SRC_SUP)] && !req[int'(SRC_PIN)]) |=> cause[int'(SRC_SUP)]);

  p_hold_window_r6: assert property (@(posedge clk) disable iff (!por_n)
    !(|req) |-> (sys_rst == (gap <= GW'(HOLD))));

  p_no_pin_on_mcd_r7: assert property (@(posedge clk) disable iff (!por_n)
    (cause[int'(SRC_MCD)] || cause[int'(SRC_PIN)]) |-> !pin_drv);
endmodule

bind rstctl_top rstctl_chk #(.HOLD(HOLD)) chk_i (
  .clk     (clk),
  .por_n   (por_n),
  .sys_rst (sys_rst),
  .pin_drv (pin_drv),
  .req     (req_vec),
  .cause   (cause_q),
  .mon_en  (mon_en),
  .sup_sel (sup_sel),
  .cmp_en  (cmp_en),
  .mcd_en  (mcd_en),
  .clk_lost(clk_lost)
);

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, clk_lost, cmp_out, sup_low;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sys_rst, pin_drv;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rstctl_top #(.HOLD(HOLD)) dut_i (
    .clk      (clk),
    .por_n    (por_n),
    .ext_rst_n(ext_rst_n),
    .clk_lost (clk_lost),
    .cmp_out  (cmp_out),
    .sup_low  (sup_low),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .sys_rst  (sys_rst),
    .pin_drv  (pin_drv)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Counts negedge samples with sys_rst high, starting at the current one.
  task automatic meas(output int n, output int drv);
    n = 0; drv = 0;
    while (sys_rst === 1'b1 && n < 1000) begin
      n++;
      if (pin_drv) drv = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(100_000 * 10);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, drv;
    por_n = 0; ext_rst_n = 1; clk_lost = 0; cmp_out = 1; sup_low = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 sys_rst during power-on", sys_rst, 1);
    por_n = 1;
    meas(n, drv);
    chk("R9 power-on stretch width", n, HOLD + 1);
    rd(0, d); chk("R9 causes after power-on", d, 8'h00);
    rd(1, d); chk("R9 R8 monitor reg after power-on", d, 8'hC0);

    // R2 disarmed
    clk_lost = 1; @(negedge clk); clk_lost = 0;
    chk("R2 disarmed clock loss ignored", sys_rst, 0);

    // R2 armed, R6 single-pulse width, R7 no pin drive
    wr(0, 8'h04);
    clk_lost = 1; @(negedge clk); clk_lost = 0;
    chk("R2 armed clock loss resets", sys_rst, 1);
    meas(n, drv);
    chk("R6 pulse width for one-cycle request", n, HOLD + 1);
    chk("R7 no pin drive on clock loss", drv, 0);
    rd(0, d); chk("R2 cause after clock loss", d, 8'h04);

    // R3 comparator
    cmp_out = 0; repeat (5) @(negedge clk);
    chk("R3 disarmed comparator ignored", sys_rst, 0);
    cmp_out = 1; repeat (3) @(negedge clk);
    wr(0, 8'h24);
    cmp_out = 0; @(negedge clk); @(negedge clk);
    chk("R3 no reset before sync delay", sys_rst, 0);
    @(negedge clk);
    chk("R3 comparator reset on third edge", sys_rst, 1);
    chk("R7 pin drive on comparator reset", pin_drv, 1);
    repeat (10) @(negedge clk);
    cmp_out = 1;
    meas(n, drv);
    chk("R6 width after held request", n, HOLD + 3);
    rd(0, d); chk("R5 only comparator cause left", d, 8'h20);

    // R4 supply
    sup_low = 1; repeat (5) @(negedge clk);
    chk("R4 not selected in source reg", sys_rst, 0);
    rd(1, d); chk("R8 live status low", d, 8'h80);
    wr(1, 8'h00); wr(0, 8'h26); repeat (4) @(negedge clk);
    chk("R4 monitor enable off", sys_rst, 0);
    wr(1, 8'h80); @(negedge clk);
    chk("R4 both enables resets", sys_rst, 1);
    chk("R7 pin drive on supply reset", pin_drv, 1);
    sup_low = 0;
    meas(n, drv);
    rd(0, d); chk("R4 supply cause", d, 8'h02);
    wr(1, 8'hFF);
    rd(1, d); chk("R8 reserved and status bits ignore writes", d, 8'hC0);

    // R1 pin
    ext_rst_n = 0; @(negedge clk); @(negedge clk);
    chk("R1 no reset before sync delay", sys_rst, 0);
    @(negedge clk);
    chk("R1 pin reset on third edge", sys_rst, 1);
    repeat (3) @(negedge clk);
    ext_rst_n = 1;
    meas(n, drv);
    chk("R7 no pin drive on pin reset", drv, 0);
    rd(0, d); chk("R1 pin cause", d, 8'h01);

    // R5 priority
    ext_rst_n = 0; sup_low = 1; repeat (4) @(negedge clk);
    ext_rst_n = 1; sup_low = 0;
    meas(n, drv);
    rd(0, d); chk("R5 pin beats supply", d, 8'h01);

    cmp_out = 0; sup_low = 1; repeat (4) @(negedge clk);
    cmp_out = 1; sup_low = 0;
    meas(n, drv);
    rd(0, d); chk("R5 supply beats comparator", d, 8'h02);

    cmp_out = 0; @(negedge clk); @(negedge clk);
    clk_lost = 1; @(negedge clk); clk_lost = 0;
    chk("R5 joint request resets", sys_rst, 1);
    cmp_out = 1;
    meas(n, drv);
    rd(0, d); chk("R5 clock loss beats comparator", d, 8'h04);

    // R2 disarm again
    wr(0, 8'h22);
    clk_lost = 1; @(negedge clk); clk_lost = 0;
    chk("R2 disarmed after write 0", sys_rst, 0);
    rd(0, d); chk("R5 write leaves causes", d, 8'h04);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule